// File: doc/BRIEF.md
# DMA Request Pin Generator

This block drives a single request pin toward an external DMA controller on behalf of a local CPU. The CPU owns a three-bit control word that selects the request style (a mode bit and a polarity bit) and carries a trigger bit that clears itself. Two request styles are supported. In level style the pin rises when the trigger is written and stays high until the external host shows an access by pulling its chip-select and register-select strobes low together. In pulse style the pin idles high and drops low for a fixed number of clock cycles once per trigger.

The host strobes are asynchronous to the block clock. They pass through a two-stage synchronizer, and a small state machine decides the pin level from the synchronized strobes, a pulse timer and the stored configuration. The machine has three states. ST_IDLE is the rest state. ST_LEVEL_ACT holds the pin high. ST_PULSE_ACT holds it low while the timer runs. An accepted trigger moves ST_IDLE to ST_LEVEL_ACT in level style, or to ST_PULSE_ACT in pulse style. ST_LEVEL_ACT returns to ST_IDLE when both synchronized strobes are low. ST_PULSE_ACT returns to ST_IDLE when the timer expires. The trigger bit reads back as 1 exactly while the machine is out of ST_IDLE.

Top module: `dreq_pin_gen`

## Requirements
- R1: After reset the read-back word `cfg_rdata` is 3'b000 and `dreq_o` is low.
- R2: The control word has the trigger in bit 0, the polarity in bit 1 and the mode in bit 2. While idle, `dreq_o` is low for mode=0/polarity=1 (level style) and high for mode=1/polarity=0 (pulse style). A write that selects one of these styles changes the pin in the cycle after the write.
- R3: In level style, a write with bit 0 set drives `dreq_o` high and `cfg_rdata[0]` to 1 from the cycle after the write.
- R4: A level request stays high while neither strobe is low, or while only one of the two strobes is low.
- R5: A level request negates no later than the third rising clock edge that samples both strobes low, and not before that edge. If the strobes are already low when the trigger is written, the request lasts one cycle.
- R6: `cfg_rdata[0]` returns to 0 in the same cycle in which the request negates.
- R7: In pulse style a trigger drives `dreq_o` low for exactly PULSE_LEN (32) clock cycles. The pin then returns high on its own.
- R8: The host strobes have no effect on the pin in pulse style, whether a pulse is running or not.
- R9: A trigger write while a request is active does not restart or extend it. A write with bit 0 clear starts nothing.
- R10: Mode/polarity combinations 0/0 and 1/1 keep `dreq_o` low, and a trigger written with either combination is ignored.
- R11: While a request is active, writes leave mode and polarity unchanged. While idle, a write stores mode and polarity, and a trigger in the same write is judged against the newly written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | CPU write strobe for the control word |
| cfg_wdata | input | 3 | Written control word: bit 2 mode, bit 1 polarity, bit 0 trigger |
| cfg_rdata | output | 3 | Read-back: stored mode, stored polarity, request active |
| host_cs_n | input | 1 | Host chip-select strobe, asynchronous, active low |
| host_rs_n | input | 1 | Host register-select strobe, asynchronous, active low |
| dreq_o | output | 1 | DMA request pin |

## Verification
The bench builds the block with its default parameters: PULSE_LEN of 32 and a two-stage synchronizer. With these values the full pulse can be checked cycle by cycle. Retriggers and locked configuration writes are placed in the middle of a pulse, and strobe activity falls inside it. The two-stage synchronizer makes the release latency an exact count of three edges, so the bench can check both that the pin stays high after the second edge and that it falls after the third.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

    localparam int CFG_W    = 3;
    localparam int BIT_TRIG = 0;
    localparam int BIT_POL  = 1;
    localparam int BIT_MODE = 2;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_LEVEL_ACT = 2'd1,
        ST_PULSE_ACT = 2'd2
    } dreq_state_e;

    typedef struct packed {
        logic mode;
        logic pol;
    } dreq_cfg_t;

    function automatic logic cfg_is_level(input logic mode, input logic pol);
        return (mode == 1'b0) && (pol == 1'b1);
    endfunction

    function automatic logic cfg_is_pulse(input logic mode, input logic pol);
        return (mode == 1'b1) && (pol == 1'b0);
    endfunction

endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
    parameter int          WIDTH     = 2,
    parameter int          STAGES    = 2,
    parameter logic [0:0]  RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[g] <= {WIDTH{RESET_VAL}};
            end else if (g == 0) begin
                stage_q[g] <= async_in;
            end else begin
                stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/dreq_cfg_reg.sv
module dreq_cfg_reg
    import dreq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             busy,
    output dreq_cfg_t        cfg,
    output logic             start_level,
    output logic             start_pulse
);

    logic accept;
    logic trig_req;

    assign accept   = we && !busy;
    assign trig_req = accept && wdata[BIT_TRIG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg.mode <= 1'b0;
            cfg.pol  <= 1'b0;
        end else if (accept) begin
            cfg.mode <= wdata[BIT_MODE];
            cfg.pol  <= wdata[BIT_POL];
        end
    end

    assign start_level = trig_req && cfg_is_level(wdata[BIT_MODE], wdata[BIT_POL]);
    assign start_pulse = trig_req && cfg_is_pulse(wdata[BIT_MODE], wdata[BIT_POL]);

endmodule

// File: rtl/dreq_pulse_timer.sv
module dreq_pulse_timer #(
    parameter int PULSE_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int CW = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(PULSE_LEN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && (cnt_q == LAST);

endmodule

// File: rtl/dreq_fsm.sv
module dreq_fsm
    import dreq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  dreq_cfg_t cfg,
    input  logic      start_level,
    input  logic      start_pulse,
    input  logic      cs_n_sync,
    input  logic      rs_n_sync,
    input  logic      pulse_done,
    output logic      busy,
    output logic      pulse_run,
    output logic      dreq
);

    dreq_state_e state_q;
    dreq_state_e state_d;
    logic        host_access;

    assign host_access = !cs_n_sync && !rs_n_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_level) begin
                    state_d = ST_LEVEL_ACT;
                end else if (start_pulse) begin
                    state_d = ST_PULSE_ACT;
                end
            end
            ST_LEVEL_ACT: begin
                if (host_access) begin
                    state_d = ST_IDLE;
                end
            end
            ST_PULSE_ACT: begin
                if (pulse_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy      = 1'b0;
        pulse_run = 1'b0;
        dreq      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                dreq = cfg_is_pulse(cfg.mode, cfg.pol);
            end
            ST_LEVEL_ACT: begin
                busy = 1'b1;
                dreq = 1'b1;
            end
            ST_PULSE_ACT: begin
                busy      = 1'b1;
                pulse_run = 1'b1;
                dreq      = 1'b0;
            end
            default: dreq = 1'b0;
        endcase
    end

endmodule

// File: rtl/dreq_pin_gen.sv
module dreq_pin_gen
    import dreq_pkg::*;
#(
    parameter int PULSE_LEN   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             host_cs_n,
    input  logic             host_rs_n,
    output logic             dreq_o
);

    dreq_cfg_t  cfg;
    logic       start_level;
    logic       start_pulse;
    logic       busy;
    logic       pulse_run;
    logic       pulse_done;
    logic [1:0] strobe_sync;

    dreq_sync #(
        .WIDTH     (2),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({host_cs_n, host_rs_n}),
        .sync_out (strobe_sync)
    );

    dreq_cfg_reg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (cfg_we),
        .wdata       (cfg_wdata),
        .busy        (busy),
        .cfg         (cfg),
        .start_level (start_level),
        .start_pulse (start_pulse)
    );

    dreq_pulse_timer #(
        .PULSE_LEN (PULSE_LEN)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (pulse_run),
        .done  (pulse_done)
    );

    dreq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg         (cfg),
        .start_level (start_level),
        .start_pulse (start_pulse),
        .cs_n_sync   (strobe_sync[1]),
        .rs_n_sync   (strobe_sync[0]),
        .pulse_done  (pulse_done),
        .busy        (busy),
        .pulse_run   (pulse_run),
        .dreq        (dreq_o)
    );

    always_comb begin
        cfg_rdata           = '0;
        cfg_rdata[BIT_MODE] = cfg.mode;
        cfg_rdata[BIT_POL]  = cfg.pol;
        cfg_rdata[BIT_TRIG] = busy;
    end

endmodule

// File: rtl/dreq_pin_gen_chk.sv
module dreq_pin_gen_chk #(
    parameter int PULSE_LEN = 32
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [2:0] cfg_wdata,
    input logic [2:0] cfg_rdata,
    input logic       host_cs_n,
    input logic       host_rs_n,
    input logic       dreq_o
);

    localparam int LW = $clog2(PULSE_LEN + 1) + 1;

    logic [1:0]    both_lo_cnt;
    logic [LW-1:0] act_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            both_lo_cnt <= '0;
        end else if (cfg_rdata[0] && !host_cs_n && !host_rs_n) begin
            if (both_lo_cnt != 2'd3) begin
                both_lo_cnt <= both_lo_cnt + 1'b1;
            end
        end else begin
            both_lo_cnt <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_cnt <= '0;
        end else if (cfg_rdata[0] && cfg_rdata[2:1] == 2'b10) begin
            if (act_cnt != {LW{1'b1}}) begin
                act_cnt <= act_cnt + 1'b1;
            end
        end else begin
            act_cnt <= '0;
        end
    end

    // R3
    level_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[0] && cfg_wdata[2:1] == 2'b01 && !cfg_rdata[0])
        |=> (dreq_o && cfg_rdata[0]));

    // R5
    level_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (both_lo_cnt == 2'd3 && cfg_rdata[2:1] == 2'b01) |-> !dreq_o);

    // R6
    trig_follows_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[2:1] == 2'b01) |-> (cfg_rdata[0] == dreq_o));

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cfg_rdata[0]) && cfg_rdata[2:1] == 2'b10)
        |-> (dreq_o && act_cnt == LW'(PULSE_LEN)));

    // R8
    pulse_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata == 3'b100) |-> dreq_o);

    // R10
    unsupported_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[2] == cfg_rdata[1]) |-> (!dreq_o && !cfg_rdata[0]));

endmodule

bind dreq_pin_gen dreq_pin_gen_chk #(
    .PULSE_LEN (PULSE_LEN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .host_cs_n (host_cs_n),
    .host_rs_n (host_rs_n),
    .dreq_o    (dreq_o)
);

// File: tb/tb_dreq_pin_gen.sv
`timescale 1ns/1ps
module tb_dreq_pin_gen;

    localparam int PULSE_LEN = 32;

    typedef struct {
        logic       dreq;
        logic [2:0] rd;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_wdata = '0;
    logic [2:0] cfg_rdata;
    logic       host_cs_n = 1'b1;
    logic       host_rs_n = 1'b1;
    logic       dreq_o;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    dreq_pin_gen #(.PULSE_LEN(PULSE_LEN), .SYNC_STAGES(2)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .host_cs_n (host_cs_n),
        .host_rs_n (host_rs_n),
        .dreq_o    (dreq_o)
    );

    // monitor: compares one scoreboard item per falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_cmp++;
            if (dreq_o !== e.dreq || cfg_rdata !== e.rd) begin
                n_bad++;
                $display("FAIL %s: dreq_o=%b cfg_rdata=%b expected dreq_o=%b cfg_rdata=%b",
                         e.tag, dreq_o, cfg_rdata, e.dreq, e.rd);
            end
        end
    end

    task automatic push_exp(input logic d, input logic [2:0] rd, input string tag);
        exp_t e;
        e.dreq = d;
        e.rd   = rd;
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    task automatic step(input logic d, input logic [2:0] rd, input string tag);
        @(posedge clk);
        push_exp(d, rd, tag);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] wd, input logic d, input logic [2:0] rd,
                      input string tag);
        cfg_we    = 1'b1;
        cfg_wdata = wd;
        @(posedge clk);
        push_exp(d, rd, tag);
        @(negedge clk);
        cfg_we    = 1'b0;
        cfg_wdata = '0;
    endtask

    task automatic strobes(input logic cs, input logic rs);
        host_cs_n = cs;
        host_rs_n = rs;
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step(1'b0, 3'b000, "R1 reset");

        // R10 unsupported combos ignore the trigger
        wr(3'b001, 1'b0, 3'b000, "R10 trigger with 0/0");
        wr(3'b111, 1'b0, 3'b110, "R10 trigger with 1/1");
        step(1'b0, 3'b110, "R10 hold low");

        // R2 level style idles low
        wr(3'b010, 1'b0, 3'b010, "R2 level idle");
        // R9 write with trigger clear starts nothing
        wr(3'b010, 1'b0, 3'b010, "R9 trigger clear");

        // R3 level trigger
        wr(3'b011, 1'b1, 3'b011, "R3 level assert");

        // R4 single strobe low keeps the request
        strobes(1'b0, 1'b1);
        for (int i = 0; i < 5; i++) step(1'b1, 3'b011, "R4 cs only low");
        strobes(1'b1, 1'b0);
        for (int i = 0; i < 5; i++) step(1'b1, 3'b011, "R4 rs only low");
        strobes(1'b1, 1'b1);
        step(1'b1, 3'b011, "R4 both high");

        // R11 config locked, R9 retrigger ignored
        wr(3'b100, 1'b1, 3'b011, "R11 config locked while active");
        wr(3'b011, 1'b1, 3'b011, "R9 retrigger in level");
        wr(3'b010, 1'b1, 3'b011, "R9 trigger clear while active");

        // R5/R6 release on the third edge
        strobes(1'b0, 1'b0);
        step(1'b1, 3'b011, "R5 edge 1 still high");
        step(1'b1, 3'b011, "R5 edge 2 still high");
        step(1'b0, 3'b010, "R5 R6 edge 3 released");

        // R5 trigger while strobes already low: one-cycle request
        wr(3'b011, 1'b1, 3'b011, "R5 trigger with strobes low");
        step(1'b0, 3'b010, "R5 R6 short request released");
        strobes(1'b1, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b0, 3'b010, "R6 idle after release");

        // R2 pulse style idles high
        wr(3'b100, 1'b1, 3'b100, "R2 pulse idle high");

        // R7 pulse, R9 retrigger, R11 lock, R8 strobes ignored
        wr(3'b101, 1'b0, 3'b101, "R7 pulse cycle 1");
        for (int i = 1; i < PULSE_LEN; i++) begin
            if (i == 15) strobes(1'b0, 1'b0);
            if (i == 21) strobes(1'b1, 1'b1);
            if (i == 10)
                wr(3'b101, 1'b0, 3'b101, "R9 retrigger in pulse");
            else if (i == 12)
                wr(3'b011, 1'b0, 3'b101, "R11 config locked in pulse");
            else if (i >= 15 && i < 21)
                step(1'b0, 3'b101, "R8 strobes during pulse");
            else
                step(1'b0, 3'b101, "R7 pulse held low");
        end
        step(1'b1, 3'b100, "R7 R6 pulse ends after 32");
        step(1'b1, 3'b100, "R7 stays high");

        // R8 strobes while idle in pulse style
        strobes(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b1, 3'b100, "R8 strobes idle pulse");
        strobes(1'b1, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b1, 3'b100, "R8 idle high");

        // R11 trigger judged against newly written values
        wr(3'b011, 1'b1, 3'b011, "R11 new config plus trigger");
        strobes(1'b0, 1'b0);
        step(1'b1, 3'b011, "R5 edge 1");
        step(1'b1, 3'b011, "R5 edge 2");
        step(1'b0, 3'b010, "R5 edge 3");
        strobes(1'b1, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b0, 3'b010, "R9 idle level");

        // R10 unsupported after supported config
        wr(3'b001, 1'b0, 3'b000, "R10 back to 0/0 with trigger");

        repeat (2) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule